// File: doc/BRIEF.md
# Two-Stage Image Line Resizer

This block rescales one dimension of a line of single-component 8-bit pixels. The first stage is a chain of power-of-two pre-decimators, each of which averages neighbouring pixel pairs. The second stage is an interpolating resampler. It walks a fixed-point phase accumulator across the decimated line and blends the two nearest pixels into each output pixel. Pixels enter on a valid/ready stream. Exactly the configured number of output pixels leaves per line, each marked by a one-cycle valid.

Before streaming, a configuration engine takes an input size and an output size. From these it derives the number of halving steps and a 14-bit step coefficient, using a sequential divider. The engine rejects sizes it cannot handle. A non-zero packed settings word skips this calculation: the halving count and step are then taken directly from the half of the word that the axis select points at. After a configuration completes, lines stream back to back with no further set-up.

Top module: `rsz_line_resizer`

## Requirements
- R1: After reset `cfgBusy`, `cfgDone`, `cfgErr`, `cfgWarn`, `outValid` and `inReady` are all 0; no pixel is accepted before a configuration completes without error.
- R2: The computed path sets `cfgErr` and keeps `inReady` at 0 when any of these holds: the input size is above 4096, the output size is above 1024, four times the output size is below the input size, or either size is 0. `cfgDecim` and `cfgStep` then read 0.
- R3: The halving count starts at 0. Up to 2 times, while the working size is above 1024 or at least twice the output size, the working size is halved (rounded down) and the count is incremented. The count appears on `cfgDecim`.
- R4: `cfgStep` = floor(8192 × (working size − 1) / (output size − 1)). An output size of 1 gives step 0.
- R5: A computed step of 16384 or more is replaced by 0x3FFF, and `cfgWarn` is set.
- R6: A non-zero `cfgPacked` bypasses the calculation and the range checks. With `cfgAxis`=0 the halving count is bits 15:14 and the step is bits 13:0. With `cfgAxis`=1 they are bits 31:30 and 29:16. A halving count of 3 is taken as 2.
- R7: `cfgBusy` is high from the edge after `cfgStart` until `cfgDone`, which pulses for one cycle as busy falls. The bypass and rejection paths finish by the second cycle. The computed path with output size above 1 takes at least 26 cycles, one per quotient bit.
- R8: Each halving stage emits (a + b + 1) >> 1 for consecutive input pairs. A trailing unpaired pixel of a line is discarded.
- R9: Output k uses phase A = k × step. Let i = A >> 13, w = A[12:5], and L = the last decimated index. If i < L, the output is (x[i]·(256 − w) + x[i+1]·w + 128) >> 8. Otherwise it is x[min(i, L)].
- R10: Each line takes exactly the input-size number of pixels and yields exactly the output-size number of outputs. The next line then starts from phase 0 with no further configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 1 | Starts a configuration (ignored while busy) |
| cfgAxis | input | 1 | Selects which half of the packed word is used (0 low, 1 high) |
| cfgPacked | input | 32 | Packed halving count and step; non-zero bypasses calculation |
| cfgInSize | input | 13 | Input pixels per line |
| cfgOutSize | input | 12 | Output pixels per line |
| cfgBusy | output | 1 | Configuration in progress |
| cfgDone | output | 1 | One-cycle pulse at the end of a configuration |
| cfgErr | output | 1 | Configuration rejected |
| cfgWarn | output | 1 | Step saturated |
| cfgDecim | output | 2 | Halving count in use |
| cfgStep | output | 14 | Step coefficient in use |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted when high with inValid |
| inPix | input | 8 | Input pixel |
| outValid | output | 1 | Output pixel valid |
| outPix | output | 8 | Output pixel |

## Verification
The bench builds the block with its default limits: 4096 input pixels, 1024 output pixels and two halving stages. This lets it reach the largest legal line, 4096 pixels in and 1024 out, with both stages active, and to step just past each limit to check rejection. The defaults also make saturation reachable with a 5-to-3 reduction, and the divide-by-zero guard with a 4-to-1 line. Packed settings cover both axis halves and the clamp of a halving count of 3.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int PIX_W  = 8;
  localparam int IN_W   = 13;
  localparam int OUT_W  = 12;
  localparam int FRAC_W = 13;
  localparam int STEP_W = 14;
  localparam int WGT_W  = 8;
  localparam int DEC_W  = 2;

  typedef struct packed {
    logic              run;
    logic              lineClr;
    logic [DEC_W-1:0]  decim;
    logic [STEP_W-1:0] step;
    logic [IN_W-1:0]   inSize;
    logic [IN_W-1:0]   wsLast;
    logic [OUT_W-1:0]  outSize;
  } rszCtl_t;
endpackage

// File: rtl/rsz_div.sv
module rsz_div #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [DEN_W:0]   trial;

  assign trial = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quo  <= num;
        cnt  <= CNT_W'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, den}) begin
          rem <= DEN_W'(trial - {1'b0, den});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
endmodule

// File: rtl/rsz_decim_stage.sv
module rsz_decim_stage
  import rsz_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             en,
  input  logic             upValid,
  input  logic [PIX_W-1:0] upPix,
  output logic             upReady,
  output logic             dnValid,
  output logic [PIX_W-1:0] dnPix,
  input  logic             dnReady
);
  logic             have;
  logic [PIX_W-1:0] held;
  logic [PIX_W:0]   pairSum;

  assign pairSum = {1'b0, held} + {1'b0, upPix} + (PIX_W+1)'(1);

  always_comb begin
    if (en) begin
      upReady = !have || dnReady;
      dnValid = have && upValid;
      dnPix   = pairSum[PIX_W:1];
    end else begin
      upReady = dnReady;
      dnValid = upValid;
      dnPix   = upPix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      have <= 1'b0;
      held <= '0;
    end else if (en && upValid && upReady) begin
      have <= !have;
      if (!have) held <= upPix;
    end
  end
endmodule

// File: rtl/rsz_ctrl.sv
module rsz_ctrl
  import rsz_pkg::*;
#(
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int MAX_DEC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic              cfgAxis,
  input  logic [31:0]       cfgPacked,
  input  logic [IN_W-1:0]   cfgInSize,
  input  logic [OUT_W-1:0]  cfgOutSize,
  output logic              cfgBusy,
  output logic              cfgDone,
  output logic              cfgErr,
  output logic              cfgWarn,
  output logic [DEC_W-1:0]  cfgDecim,
  output logic [STEP_W-1:0] cfgStep,
  output rszCtl_t           ctl
);
  localparam int NUM_W = IN_W + FRAC_W;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DIV} state_t;
  state_t state;

  logic [IN_W-1:0]  inSizeR, wsR, wsCalc, pkWs;
  logic [OUT_W-1:0] outSizeR;
  logic [31:0]      packedR;
  logic             axisR, okR, rangeErr, divStart, divDone;
  logic [DEC_W-1:0] dCalc, pkDec;
  logic [15:0]      pkField;
  logic [NUM_W-1:0] quo;
  logic [IN_W:0]    outX2;

  assign outX2   = (IN_W+1)'({outSizeR, 1'b0});
  assign pkField = axisR ? packedR[31:16] : packedR[15:0];
  assign pkDec   = (pkField[15:14] > DEC_W'(MAX_DEC)) ? DEC_W'(MAX_DEC) : pkField[15:14];
  assign pkWs    = inSizeR >> pkDec;

  assign rangeErr = (inSizeR > IN_W'(MAX_IN)) || (outSizeR > OUT_W'(MAX_OUT)) ||
                    ((IN_W+2)'({outSizeR, 2'b00}) < (IN_W+2)'(inSizeR)) ||
                    (inSizeR == '0) || (outSizeR == '0);

  always_comb begin
    wsCalc = inSizeR;
    dCalc  = '0;
    for (int k = 0; k < MAX_DEC; k++) begin
      if (wsCalc > IN_W'(MAX_OUT) || (IN_W+1)'(wsCalc) >= outX2) begin
        wsCalc = wsCalc >> 1;
        dCalc  = dCalc + 1'b1;
      end
    end
  end

  assign divStart = (state == S_EVAL) && (packedR == '0) && !rangeErr &&
                    (outSizeR != OUT_W'(1));

  rsz_div #(.NUM_W(NUM_W), .DEN_W(OUT_W)) i_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (divStart),
    .num   ({wsCalc - 1'b1, FRAC_W'(0)}),
    .den   (outSizeR - 1'b1),
    .done  (divDone),
    .quo   (quo)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      inSizeR  <= '0;
      outSizeR <= '0;
      packedR  <= '0;
      axisR    <= 1'b0;
      wsR      <= '0;
      okR      <= 1'b0;
      cfgErr   <= 1'b0;
      cfgWarn  <= 1'b0;
      cfgDecim <= '0;
      cfgStep  <= '0;
      cfgDone  <= 1'b0;
    end else begin
      cfgDone <= 1'b0;
      case (state)
        S_IDLE: if (cfgStart) begin
          inSizeR  <= cfgInSize;
          outSizeR <= cfgOutSize;
          packedR  <= cfgPacked;
          axisR    <= cfgAxis;
          okR      <= 1'b0;
          cfgErr   <= 1'b0;
          cfgWarn  <= 1'b0;
          state    <= S_EVAL;
        end
        S_EVAL: begin
          if (packedR != '0) begin
            cfgDecim <= pkDec;
            cfgStep  <= pkField[STEP_W-1:0];
            wsR      <= pkWs;
            okR      <= 1'b1;
            cfgDone  <= 1'b1;
            state    <= S_IDLE;
          end else if (rangeErr) begin
            cfgDecim <= '0;
            cfgStep  <= '0;
            cfgErr   <= 1'b1;
            cfgDone  <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cfgDecim <= dCalc;
            wsR      <= wsCalc;
            if (outSizeR == OUT_W'(1)) begin
              cfgStep <= '0;
              okR     <= 1'b1;
              cfgDone <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_DIV;
            end
          end
        end
        S_DIV: if (divDone) begin
          if (|quo[NUM_W-1:STEP_W]) begin
            cfgStep <= '1;
            cfgWarn <= 1'b1;
          end else begin
            cfgStep <= quo[STEP_W-1:0];
          end
          okR     <= 1'b1;
          cfgDone <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfgBusy     = (state != S_IDLE);
  assign ctl.run     = okR && (state == S_IDLE);
  assign ctl.lineClr = (state == S_IDLE) && cfgStart;
  assign ctl.decim   = cfgDecim;
  assign ctl.step    = cfgStep;
  assign ctl.inSize  = inSizeR;
  assign ctl.wsLast  = wsR - 1'b1;
  assign ctl.outSize = outSizeR;

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> (!cfgBusy && $past(cfgBusy))); // R7
  AST_WARN_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    cfgWarn |-> (cfgStep == '1)); // R5
  AST_ERR_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !ctl.run); // R2
  AST_DECIM_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> (cfgDecim <= DEC_W'(MAX_DEC))); // R3
endmodule

// File: rtl/rsz_datapath.sv
module rsz_datapath
  import rsz_pkg::*;
#(
  parameter int MAX_DEC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  rszCtl_t          ctl,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inPix,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix
);
  localparam int ACC_W = FRAC_W + IN_W + 1;
  localparam int SUM_W = PIX_W + WGT_W + 1;

  logic [MAX_DEC:0] sV, sR;
  logic [PIX_W-1:0] sP [MAX_DEC+1];

  logic [PIX_W-1:0] p0, p1, bSel;
  logic [1:0]       cnt;
  logic [IN_W-1:0]  idx, inCnt;
  logic [OUT_W-1:0] outCnt;
  logic [ACC_W-1:0] acc;
  logic [IN_W:0]    accInt, idxX;
  logic [WGT_W-1:0] wgt;
  logic [WGT_W:0]   wInv;
  logic [SUM_W-1:0] blend;
  logic lastPix, outDone, emit, drop, take, lineEnd, clr;

  assign clr     = ctl.lineClr || lineEnd;
  assign inReady = ctl.run && (inCnt != ctl.inSize) && sR[0];
  assign sV[0]   = inValid && inReady;
  assign sP[0]   = inPix;

  for (genvar k = 0; k < MAX_DEC; k++) begin : g_dec
    rsz_decim_stage i_stage (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (clr),
      .en      (DEC_W'(k) < ctl.decim),
      .upValid (sV[k]),
      .upPix   (sP[k]),
      .upReady (sR[k]),
      .dnValid (sV[k+1]),
      .dnPix   (sP[k+1]),
      .dnReady (sR[k+1])
    );
  end

  assign accInt  = acc[ACC_W-1:FRAC_W];
  assign idxX    = {1'b0, idx};
  assign lastPix = (idx == ctl.wsLast);
  assign outDone = (outCnt == ctl.outSize);
  assign sR[MAX_DEC] = (cnt < 2'd2) || outDone;
  assign take    = sV[MAX_DEC] && sR[MAX_DEC] && !outDone;
  assign emit    = ctl.run && !outDone && (cnt != 2'd0) &&
                   (lastPix ? (accInt >= idxX) : ((cnt == 2'd2) && (accInt == idxX)));
  assign drop    = ctl.run && !outDone && !lastPix && (cnt == 2'd2) && (accInt > idxX);
  assign lineEnd = ctl.run && (inCnt == ctl.inSize) && outDone;

  assign wgt   = acc[FRAC_W-1 -: WGT_W];
  assign wInv  = (WGT_W+1)'(1 << WGT_W) - (WGT_W+1)'(wgt);
  assign bSel  = (cnt == 2'd2) ? p1 : p0;
  assign blend = SUM_W'(p0) * SUM_W'(wInv) + SUM_W'(bSel) * SUM_W'(wgt) +
                 SUM_W'(1 << (WGT_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      p0       <= '0;
      p1       <= '0;
      cnt      <= '0;
      idx      <= '0;
      inCnt    <= '0;
      outCnt   <= '0;
      acc      <= '0;
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      if (sV[0]) inCnt <= inCnt + 1'b1;
      if (take) begin
        if (cnt == 2'd0) begin
          p0  <= sP[MAX_DEC];
          cnt <= 2'd1;
        end else begin
          p1  <= sP[MAX_DEC];
          cnt <= 2'd2;
        end
      end
      if (drop) begin
        p0  <= p1;
        cnt <= 2'd1;
        idx <= idx + 1'b1;
      end
      if (emit) begin
        acc    <= acc + ACC_W'(ctl.step);
        outCnt <= outCnt + 1'b1;
      end
      outValid <= emit;
      outPix   <= blend[WGT_W +: PIX_W];
    end
  end

  AST_OUT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= ctl.outSize || !ctl.run); // R10
  AST_IN_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (inCnt <= ctl.inSize)); // R10
  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    cnt != 2'd3); // R9
endmodule

// File: rtl/rsz_line_resizer.sv
module rsz_line_resizer
  import rsz_pkg::*;
#(
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int MAX_DEC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStart,
  input  logic              cfgAxis,
  input  logic [31:0]       cfgPacked,
  input  logic [IN_W-1:0]   cfgInSize,
  input  logic [OUT_W-1:0]  cfgOutSize,
  output logic              cfgBusy,
  output logic              cfgDone,
  output logic              cfgErr,
  output logic              cfgWarn,
  output logic [DEC_W-1:0]  cfgDecim,
  output logic [STEP_W-1:0] cfgStep,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  inPix,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPix
);
  rszCtl_t ctl;

  rsz_ctrl #(.MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT), .MAX_DEC(MAX_DEC)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgStart   (cfgStart),
    .cfgAxis    (cfgAxis),
    .cfgPacked  (cfgPacked),
    .cfgInSize  (cfgInSize),
    .cfgOutSize (cfgOutSize),
    .cfgBusy    (cfgBusy),
    .cfgDone    (cfgDone),
    .cfgErr     (cfgErr),
    .cfgWarn    (cfgWarn),
    .cfgDecim   (cfgDecim),
    .cfgStep    (cfgStep),
    .ctl        (ctl)
  );

  rsz_datapath #(.MAX_DEC(MAX_DEC)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inValid  (inValid),
    .inReady  (inReady),
    .inPix    (inPix),
    .outValid (outValid),
    .outPix   (outPix)
  );
endmodule

// File: tb/test_rsz_line_resizer.sv
`timescale 1ns/1ps
module test_rsz_line_resizer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgStart = 1'b0, cfgAxis = 1'b0;
  logic [31:0] cfgPacked = '0;
  logic [12:0] cfgInSize = '0;
  logic [11:0] cfgOutSize = '0;
  logic        cfgBusy, cfgDone, cfgErr, cfgWarn;
  logic [1:0]  cfgDecim;
  logic [13:0] cfgStep;
  logic        inValid = 1'b0, inReady;
  logic [7:0]  inPix = '0;
  logic        outValid;
  logic [7:0]  outPix;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit wdFired = 0;
  int expQ[$];
  int eErr, eWarn, eDec, eStep, eWs;
  int pix[4096];
  int lvl[4096];

  always #2.5 clk = ~clk;

  rsz_line_resizer i_rsz_line_resizer (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgAxis(cfgAxis),
    .cfgPacked(cfgPacked), .cfgInSize(cfgInSize), .cfgOutSize(cfgOutSize),
    .cfgBusy(cfgBusy), .cfgDone(cfgDone), .cfgErr(cfgErr), .cfgWarn(cfgWarn),
    .cfgDecim(cfgDecim), .cfgStep(cfgStep), .inValid(inValid), .inReady(inReady),
    .inPix(inPix), .outValid(outValid), .outPix(outPix)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected pixels as the design produces them (R9, R10)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) chk("R10 unexpected output", 1, 0);
      else chk("R9 output pixel", int'(outPix), expQ.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !wdFired) begin
      wdFired = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic modelCfg(input int inS, input int outS, input logic [31:0] pk, input logic ax);
    logic [15:0] f;
    eErr = 0; eWarn = 0; eDec = 0; eStep = 0; eWs = 0;
    if (pk != 0) begin
      f = ax ? pk[31:16] : pk[15:0];
      eDec = (int'(f[15:14]) > 2) ? 2 : int'(f[15:14]);
      eStep = int'(f[13:0]);
      eWs = inS >> eDec;
    end else if (inS > 4096 || outS > 1024 || outS * 4 < inS || inS == 0 || outS == 0) begin
      eErr = 1;
    end else begin
      eWs = inS;
      for (int k = 0; k < 2; k++)
        if (eWs > 1024 || eWs >= 2 * outS) begin eWs = eWs / 2; eDec++; end
      if (outS == 1) eStep = 0;
      else begin
        eStep = (8192 * (eWs - 1)) / (outS - 1);
        if (eStep >= 16384) begin eStep = 16383; eWarn = 1; end
      end
    end
  endtask

  task automatic runCfg(input int inS, input int outS, input logic [31:0] pk,
                        input logic ax, input int minCyc, input int maxCyc);
    int n;
    modelCfg(inS, outS, pk, ax);
    @(negedge clk);
    cfgInSize = 13'(inS); cfgOutSize = 12'(outS); cfgPacked = pk; cfgAxis = ax;
    cfgStart = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
    n = 1;
    chk("R7 busy after start", int'(cfgBusy), 1);
    while (!cfgDone) begin @(negedge clk); n++; end
    chk("R7 busy cleared at done", int'(cfgBusy), 0);
    if (n < minCyc || n > maxCyc) chk("R7 config latency", n, minCyc);
    else chk("R7 config latency", n, n);
    chk("R2 error flag", int'(cfgErr), eErr);
    chk("R5 warn flag", int'(cfgWarn), eWarn);
    chk("R3/R6 decim R3", int'(cfgDecim), eDec);
    chk("R4/R6 step R4", int'(cfgStep), eStep);
    @(negedge clk);
    chk("R7 done is a pulse", int'(cfgDone), 0);
  endtask

  task automatic runLine(input int inS, input int outS, input int seed);
    int len, acc, ip, w, a, b, guard;
    for (int i = 0; i < inS; i++) begin
      pix[i] = (i * 37 + seed * 11 + (i * i) % 7) & 255;
      lvl[i] = pix[i];
    end
    len = inS;
    for (int d = 0; d < eDec; d++) begin // R8 pair averaging, odd tail dropped
      for (int i = 0; i < len / 2; i++) lvl[i] = (lvl[2*i] + lvl[2*i+1] + 1) / 2;
      len = len / 2;
    end
    acc = 0;
    for (int k = 0; k < outS; k++) begin
      ip = acc >> 13; w = (acc >> 5) & 255;
      if (ip < len - 1) begin a = lvl[ip]; b = lvl[ip + 1]; end
      else begin a = lvl[len - 1]; b = a; end
      expQ.push_back((a * (256 - w) + b * w + 128) >> 8);
      acc += eStep;
    end
    for (int i = 0; i < inS; i++) begin
      if (i % 5 == 3) begin inValid = 1'b0; @(negedge clk); end
      inValid = 1'b1; inPix = 8'(pix[i]);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    guard = 0;
    while (expQ.size() != 0 && guard < 20000) begin @(negedge clk); guard++; end
    chk("R10 all outputs produced", expQ.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkBlocked(input string tag);
    inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tag, int'(inReady), 0);
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(cfgBusy), 0);
    chk("R1 done", int'(cfgDone), 0);
    chk("R1 err", int'(cfgErr), 0);
    chk("R1 warn", int'(cfgWarn), 0);
    chk("R1 outValid", int'(outValid), 0);
    checkBlocked("R1 inReady before config");

    runCfg(8, 4, 32'h0, 1'b0, 26, 40);        // R3 one halving, R4 step 8192
    runLine(8, 4, 1);
    runCfg(4, 7, 32'h0, 1'b0, 26, 40);        // R9 upscaling
    runLine(4, 7, 2);
    runLine(4, 7, 3);                          // R10 second line, no reconfig
    runCfg(5, 3, 32'h0, 1'b0, 26, 40);        // R5 saturation
    runLine(5, 3, 4);
    runCfg(4, 1, 32'h0, 1'b0, 1, 3);          // R4 output size 1
    runLine(4, 1, 5);
    runCfg(7, 3, 32'h0, 1'b0, 26, 40);        // R8 odd tail
    runLine(7, 3, 6);
    runCfg(6, 4, 32'h0, 1'b0, 26, 40);        // R9 fractional weights
    runLine(6, 4, 7);
    runLine(6, 4, 8);
    runCfg(8, 2, 32'h0, 1'b0, 26, 40);        // R2 exactly 4:1 accepted
    runLine(8, 2, 9);
    runCfg(4096, 1024, 32'h0, 1'b0, 26, 40);  // R3 two halvings at the limits
    runLine(4096, 1024, 10);

    runCfg(4097, 1024, 32'h0, 1'b0, 1, 3);    // R2 input too large
    checkBlocked("R2 blocked after input too large");
    runCfg(100, 1025, 32'h0, 1'b0, 1, 3);     // R2 output too large
    checkBlocked("R2 blocked after output too large");
    runCfg(9, 2, 32'h0, 1'b0, 1, 3);          // R2 beyond 4:1
    checkBlocked("R2 blocked after excess reduction");
    runCfg(0, 4, 32'h0, 1'b0, 1, 3);          // R2 zero size
    checkBlocked("R2 blocked after zero size");

    runCfg(8, 7, {16'd0, 2'd1, 14'd4096}, 1'b0, 1, 3);  // R6 low half
    runLine(8, 7, 11);
    runCfg(8, 2, {2'd3, 14'd8192, 16'd0}, 1'b1, 1, 3);  // R6 high half, clamp
    runLine(8, 2, 12);
    runCfg(4, 4, {2'd0, 14'd8192, 2'd2, 14'd100}, 1'b1, 1, 3); // R6 axis picks high
    runLine(4, 4, 13);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule